// File: doc/BRIEF.md
# Video Parallel Output Formatter

This block sits after word recovery in a serial video receiver. It places recovered video samples or transport-stream words on a 20-bit parallel output bus. It also produces a clock enable that marks each new output word. The block runs on one clock at twice the co-sited pair rate. In 20-bit mode a pair is placed side by side once every two cycles. In 10-bit mode the two words of a pair share the upper lane and the output changes every cycle. The block also reports a code for the parallel clock frequency that matches the active format, so that downstream clocking can be set to suit.

Four mode inputs select the format: narrow (10-bit) versus wide (20-bit), HD versus SD, a raw data-through request, and a transport-stream (DVB-ASI) flag. The transport-stream flag overrides everything else and always selects the 10-bit format. The data-through request is honoured only when a strap input says that the mode pins are driven from outside. The mode inputs are sampled only on a start-of-line strobe, so no output word mixes two formats. The same strobe also restarts the pairing phase.

Top module: `vfmt_out`

## Requirements
- R1: While reset is asserted and after its release until the first capture, `dout_o` is 0, `pclk_en_o` is 0 and `rate_code_o` is 0. The active format after reset is wide video, SD.
- R2: In wide video format, the pair is captured in each phase-0 cycle. From the next edge, `dout_o[19:10]` = `word_a_i` (luma) and `dout_o[9:0]` = `word_b_i` (chroma), with `pclk_en_o` = 1. After a phase-1 cycle, `pclk_en_o` = 0 and `dout_o` holds its value.
- R3: In narrow video format, `pclk_en_o` is 1 after every cycle and `dout_o[9:0]` is 0. A phase-0 cycle places `word_b_i` (chroma) on bits 19:10 and keeps `word_a_i`. The following phase-1 cycle places that kept luma word on bits 19:10.
- R4: With `asi_i` set, every cycle places `word_a_i` on bits 19:10 and forces bits 9:0 to 0, with `pclk_en_o` = 1. This holds whatever `width_narrow_i`, `hd_i` and `bypass_i` say.
- R5: `bypass_i` selects raw data-through only when `pins_ext_i` = 1. In raw wide format the mapping is that of R2. In raw narrow format the order is `word_a_i` first and then `word_b_i`. With `pins_ext_i` = 0 the request is ignored and video behaviour applies.
- R6: `rate_code_o` encodes the parallel clock: 0 = 13.5 MHz (SD wide), 1 = 27 MHz (SD narrow or transport stream), 2 = 74.25 MHz (HD wide), 3 = 148.5 MHz (HD narrow). The /1.001 variants follow the input clock.
- R7: Mode inputs are sampled only in a cycle with `sol_i` = 1, and that cycle already uses the new format. Mode changes between strobes have no effect on `dout_o`, `pclk_en_o` or `rate_code_o`.
- R8: A cycle with `sol_i` = 1 is always a phase-0 (capture) cycle, even if it arrives in the middle of a pair. Phase then alternates each cycle. Phase is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Doubled-rate word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sol_i | input | 1 | Start-of-line strobe; samples modes, restarts phase |
| width_narrow_i | input | 1 | 1 = 10-bit multiplexed, 0 = 20-bit side by side |
| hd_i | input | 1 | 1 = HD, 0 = SD |
| bypass_i | input | 1 | Raw data-through request |
| asi_i | input | 1 | Transport-stream mode, forces 10-bit |
| pins_ext_i | input | 1 | 1 = mode pins driven externally (data-through allowed) |
| word_a_i | input | 10 | Luma word, or transport/raw word |
| word_b_i | input | 10 | Chroma word, or second raw word |
| dout_o | output | 20 | Parallel output bus |
| pclk_en_o | output | 1 | Marks a new output word |
| rate_code_o | output | 2 | Parallel clock frequency code |

## Verification
The bench goes after the interleave order. A design that swapped luma and chroma in narrow video, or that kept the video order in raw narrow mode, shows the wrong word first on the upper lane. It raises mode pins mid-line without a strobe; a design that followed the pins at once would change format and rate code mid-line. It sends strobes that land in phase 1. A design that did not restart the phase would capture off by one cycle, which is seen as stale held data or a missing enable. It also combines the transport-stream flag with the wide, HD and bypass settings, and sends a bypass request with the strap low. A design that let either of these through would show lower-lane data or the raw word order.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

  typedef enum logic [2:0] {
    FMT_VID_DMX = 3'd0,
    FMT_VID_MUX = 3'd1,
    FMT_RAW_DMX = 3'd2,
    FMT_RAW_MUX = 3'd3,
    FMT_TS      = 3'd4
  } fmt_e;

  typedef enum logic [1:0] {
    RATE_13M5  = 2'd0,
    RATE_27M   = 2'd1,
    RATE_74M25 = 2'd2,
    RATE_148M5 = 2'd3
  } rate_e;

  typedef struct packed {
    fmt_e fmt;
    logic hd;
  } mode_t;

  // Transport stream wins, then an honoured raw request, then video.
  function automatic mode_t decode_mode(input logic narrow, input logic hd,
                                        input logic raw_req, input logic ts,
                                        input logic ext);
    mode_t m;
    m.hd = hd;
    if (ts)
      m.fmt = FMT_TS;
    else if (raw_req && ext)
      m.fmt = narrow ? FMT_RAW_MUX : FMT_RAW_DMX;
    else
      m.fmt = narrow ? FMT_VID_MUX : FMT_VID_DMX;
    return m;
  endfunction

  function automatic rate_e rate_of(input mode_t m);
    rate_e r;
    case (m.fmt)
      FMT_TS:                   r = RATE_27M;
      FMT_VID_MUX, FMT_RAW_MUX: r = m.hd ? RATE_148M5 : RATE_27M;
      default:                  r = m.hd ? RATE_74M25 : RATE_13M5;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vfmt_mode_ctl.sv
module vfmt_mode_ctl
  import vfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sol_i,
  input  logic       width_narrow_i,
  input  logic       hd_i,
  input  logic       bypass_i,
  input  logic       asi_i,
  input  logic       pins_ext_i,
  output fmt_e       fmt_cur_o,
  output logic       phase_cur_o,
  output logic [1:0] rate_code_o
);

  mode_t mode_q, mode_n, mode_cur;
  logic  ph_q, ph_n, ph_cur;

  // Format and phase that apply in this cycle
  always_comb begin
    mode_cur = mode_q;
    ph_cur   = ph_q;
    if (sol_i) begin
      mode_cur = decode_mode(width_narrow_i, hd_i, bypass_i, asi_i, pins_ext_i);
      ph_cur   = 1'b0;
    end
    mode_n = mode_cur;
    ph_n   = ~ph_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{fmt: FMT_VID_DMX, hd: 1'b0};
      ph_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      ph_q   <= ph_n;
    end
  end

  assign fmt_cur_o   = mode_cur.fmt;
  assign phase_cur_o = ph_cur;
  assign rate_code_o = rate_of(mode_q);

endmodule

// File: rtl/vfmt_lane_mux.sv
module vfmt_lane_mux
  import vfmt_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int BUS_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_cur_i,
  input  logic              phase_cur_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  output logic [BUS_W-1:0]  dout_o,
  output logic              pclk_en_o
);

  localparam logic [WORD_W-1:0] LANE_LOW = '0;

  logic [BUS_W-1:0]  dout_q, dout_n;
  logic              en_q, en_n;
  logic [WORD_W-1:0] keep_q, keep_n;

  always_comb begin
    dout_n = dout_q;
    en_n   = 1'b0;
    keep_n = keep_q;
    case (fmt_cur_i)
      FMT_VID_DMX, FMT_RAW_DMX: begin
        if (!phase_cur_i) begin
          dout_n = {word_a_i, word_b_i};
          en_n   = 1'b1;
        end
      end
      FMT_VID_MUX: begin
        en_n = 1'b1;
        if (!phase_cur_i) begin
          dout_n = {word_b_i, LANE_LOW};
          keep_n = word_a_i;
        end else begin
          dout_n = {keep_q, LANE_LOW};
        end
      end
      FMT_RAW_MUX: begin
        en_n = 1'b1;
        if (!phase_cur_i) begin
          dout_n = {word_a_i, LANE_LOW};
          keep_n = word_b_i;
        end else begin
          dout_n = {keep_q, LANE_LOW};
        end
      end
      FMT_TS: begin
        en_n   = 1'b1;
        dout_n = {word_a_i, LANE_LOW};
      end
      default: begin
        dout_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      en_q   <= 1'b0;
      keep_q <= '0;
    end else begin
      dout_q <= dout_n;
      en_q   <= en_n;
      keep_q <= keep_n;
    end
  end

  assign dout_o    = dout_q;
  assign pclk_en_o = en_q;

endmodule

// File: rtl/vfmt_out.sv
module vfmt_out
  import vfmt_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sol_i,
  input  logic                  width_narrow_i,
  input  logic                  hd_i,
  input  logic                  bypass_i,
  input  logic                  asi_i,
  input  logic                  pins_ext_i,
  input  logic [WORD_W-1:0]     word_a_i,
  input  logic [WORD_W-1:0]     word_b_i,
  output logic [2*WORD_W-1:0]   dout_o,
  output logic                  pclk_en_o,
  output logic [1:0]            rate_code_o
);

  fmt_e fmt_cur;
  logic phase_cur;

  vfmt_mode_ctl u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .sol_i          (sol_i),
    .width_narrow_i (width_narrow_i),
    .hd_i           (hd_i),
    .bypass_i       (bypass_i),
    .asi_i          (asi_i),
    .pins_ext_i     (pins_ext_i),
    .fmt_cur_o      (fmt_cur),
    .phase_cur_o    (phase_cur),
    .rate_code_o    (rate_code_o)
  );

  vfmt_lane_mux #(.WORD_W(WORD_W)) u_lanes (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_cur_i   (fmt_cur),
    .phase_cur_i (phase_cur),
    .word_a_i    (word_a_i),
    .word_b_i    (word_b_i),
    .dout_o      (dout_o),
    .pclk_en_o   (pclk_en_o)
  );

endmodule

// File: rtl/vfmt_out_chk.sv
module vfmt_out_chk #(
  parameter int WORD_W = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sol_i,
  input logic [2*WORD_W-1:0] dout_o,
  input logic                pclk_en_o,
  input logic [1:0]          rate_code_o
);

  // R3 R4
  lower_lane_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_code_o[0] |-> (dout_o[WORD_W-1:0] == '0));

  // R3 R4
  narrow_every_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_code_o[0] |-> pclk_en_o);

  // R2
  wide_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_code_o[0] && pclk_en_o && !sol_i) |=> (!pclk_en_o && $stable(dout_o)));

  // R7
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sol_i |=> $stable(rate_code_o));

endmodule

bind vfmt_out vfmt_out_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sol_i       (sol_i),
  .dout_o      (dout_o),
  .pclk_en_o   (pclk_en_o),
  .rate_code_o (rate_code_o)
);

// File: tb/vfmt_out_tb.sv
module vfmt_out_tb;
  localparam int W = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, sol, narrow, hd, byp, asi, ext;
  logic [W-1:0]   wa, wb;
  logic [2*W-1:0] dout;
  logic           pen;
  logic [1:0]     rate;

  vfmt_out #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sol_i(sol), .width_narrow_i(narrow), .hd_i(hd),
    .bypass_i(byp), .asi_i(asi), .pins_ext_i(ext), .word_a_i(wa), .word_b_i(wb),
    .dout_o(dout), .pclk_en_o(pen), .rate_code_o(rate)
  );

  typedef struct {
    logic [2*W-1:0] dout;
    logic           en;
    logic [1:0]     rate;
    string          tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   seed  = 0;

  // Bench model: 0 wide video, 1 narrow video, 2 raw wide, 3 raw narrow, 4 transport
  int             m_fmt = 0;
  logic           m_hd  = 1'b0;
  logic           m_ph  = 1'b0;
  logic [W-1:0]   m_keep = '0;
  logic [2*W-1:0] m_dout = '0;
  localparam logic [W-1:0] Z = '0;

  task automatic step(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                      input string tag);
    exp_t e;
    sol = s; wa = a; wb = b;
    if (s) begin
      if (asi)             m_fmt = 4;
      else if (byp && ext) m_fmt = narrow ? 3 : 2;
      else                 m_fmt = narrow ? 1 : 0;
      m_hd = hd;
      m_ph = 1'b0;
    end
    e.en = 1'b1;
    case (m_fmt)
      0, 2: if (!m_ph) m_dout = {a, b}; else e.en = 1'b0;
      1: if (!m_ph) begin m_dout = {b, Z}; m_keep = a; end else m_dout = {m_keep, Z};
      3: if (!m_ph) begin m_dout = {a, Z}; m_keep = b; end else m_dout = {m_keep, Z};
      default: m_dout = {a, Z};
    endcase
    if (m_fmt == 4)          e.rate = 2'd1;
    else if (m_fmt % 2 == 1) e.rate = m_hd ? 2'd3 : 2'd1;
    else                     e.rate = m_hd ? 2'd2 : 2'd0;
    m_ph   = ~m_ph;
    e.dout = m_dout;
    e.tag  = tag;
    @(posedge clk);
    #1 sb_q.push_back(e);
    #2;
  endtask

  task automatic run(input int n, input logic first_sol, input string tag);
    for (int k = 0; k < n; k++) begin
      seed = seed + 1;
      step(first_sol && (k == 0), W'(10'h101 + seed * 37), W'(10'h2a3 + seed * 53), tag);
    end
    sol = 1'b0;
  endtask

  // Monitor: compares each pushed expectation well after its edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #8;
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_cmp++;
        if (dout !== e.dout || pen !== e.en || rate !== e.rate) begin
          n_bad++;
          $display("FAIL %s: dout=%h en=%b rate=%0d expected dout=%h en=%b rate=%0d",
                   e.tag, dout, pen, rate, e.dout, e.en, e.rate);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sol = 1'b0; narrow = 1'b0; hd = 1'b0; byp = 1'b0;
    asi = 1'b0; ext = 1'b0; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    #5;
    n_cmp++;
    if (dout !== '0 || pen !== 1'b0 || rate !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: dout=%h en=%b rate=%0d expected dout=0 en=0 rate=0", dout, pen, rate);
    end
    @(posedge clk); #3 rst_n = 1'b1;

    // R1: default format after reset, no strobe yet
    run(2, 1'b0, "R1");
    // R2 and R6: wide SD video
    run(6, 1'b1, "R2");
    // R7: pins change mid-line, no strobe
    narrow = 1'b1; hd = 1'b1; asi = 1'b1;
    run(4, 1'b0, "R7");
    asi = 1'b0;
    // R3 and R6: narrow HD video
    run(6, 1'b1, "R3");
    // R8: strobe arriving in phase 1, narrow
    run(3, 1'b1, "R8");
    run(4, 1'b1, "R8");
    // R6: narrow SD and wide HD
    hd = 1'b0;
    run(4, 1'b1, "R6");
    narrow = 1'b0; hd = 1'b1;
    run(4, 1'b1, "R6");
    // R8: strobe arriving in phase 1, wide
    run(3, 1'b1, "R8");
    run(4, 1'b1, "R8");
    // R4: transport stream overrides width, HD and bypass
    asi = 1'b1; byp = 1'b1; ext = 1'b1; narrow = 1'b0;
    run(5, 1'b1, "R4");
    asi = 1'b0;
    // R5: bypass ignored with strap low, then honoured
    narrow = 1'b1; ext = 1'b0; hd = 1'b0;
    run(4, 1'b1, "R5");
    ext = 1'b1;
    run(4, 1'b1, "R5");
    narrow = 1'b0;
    run(4, 1'b1, "R5");

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule